// File: doc/BRIEF.md
# Pipelined Vectoring CORDIC

This block converts a stream of signed Cartesian vectors into polar form. Each clock it can accept one vector (x, y) together with a starting angle and a valid flag. It returns the vector's length, multiplied by the fixed CORDIC gain, and the sum of the starting angle and the vector's own angle. The work is done by a chain of registered shift-add/subtract stages. Stage i rotates the vector by ±atan(2^-i), and the sign of y picks the direction, so the vector turns toward the positive x-axis. The shift in each stage is a constant and costs only wiring. The arctangent for each stage is a constant, computed when the design is elaborated.

The basic iterations only converge for vectors in the right half-plane. A registered front stage therefore turns any vector with negative x by a quarter turn first, and it adds or subtracts that quarter turn to the angle. After this step the whole plane is covered.

The length is left uncompensated and carries a gain of about 1.647. Two guard bits on the x and y paths keep the largest possible result inside range. Angles are signed two's complement, with half a turn equal to 2^(AW-1), and they wrap modulo a full turn.

Top module: `cordic_vec_top`

## Requirements
- R1: A sample accepted with `in_valid` high appears with `out_valid` high exactly STAGES+1 clocks later. Back-to-back inputs give back-to-back results, in the order they were accepted.
- R2: While `rst` is high (synchronous, active high), `out_valid` is low. Samples offered during reset never produce an output.
- R3: For x ≥ 0, `out_mag` equals G·sqrt(x²+y²) within STAGES+4 LSB, where G is the product of sqrt(1+2^-2i) for i = 0 to STAGES-1.
- R4: For x < 0, the quarter-turn front stage makes both `out_mag` and `out_phase` meet the same accuracy as in the right half-plane.
- R5: `out_phase` equals `in_phase` + atan2(y, x), in units where 2^(AW-1) is half a turn, modulo 2^AW. The tolerance is 10 LSB plus 2·STAGES·2^(AW-1)/(π·|v|) LSB, and the check applies when |v| ≥ 512.
- R6: The input vector (0, 0) gives `out_mag` = 0 exactly.
- R7: Full-scale inputs, including (-2^(W-1), -2^(W-1)), never overflow. `out_mag` stays non-negative and within the R3 tolerance.
- R8: When no sample arrives in a slot, `out_valid` is low in the matching output cycle, and `out_mag` and `out_phase` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_x | input | W | Signed x component |
| in_y | input | W | Signed y component |
| in_phase | input | AW | Starting angle, two's complement, 2^(AW-1) = half a turn |
| out_valid | output | 1 | Result valid |
| out_mag | output | W+2 | Gain-scaled magnitude, non-negative |
| out_phase | output | AW | Starting angle plus vector angle, wrapped |

## Verification
The hardest cases to reach lie on the quarter-turn boundary. These are vectors with negative x and a y of zero or either sign, where the front stage's direction choice decides whether the phase lands near +π or −π. The hardest case for range is the most negative corner, where the guard bits are fully used. Directed samples place vectors on each axis, at the four full-scale corners and at the origin. Seeded random vectors, sent in bursts with random gaps, then cover the rest of the plane, check ordering through the pipeline, and check that outputs hold during empty slots.

// File: rtl/cordic_vec_pkg.sv
package cordic_vec_pkg;

  // Headroom bits added to the x/y datapath for the ~1.647 growth.
  localparam int GUARD = 2;

  // atan(2^-i) with half a turn = 2^31.
  function automatic logic [31:0] atan_q31(input int i);
    case (i)
      0:  return 32'h20000000;
      1:  return 32'h12E4051E;
      2:  return 32'h09FB385B;
      3:  return 32'h051111D4;
      4:  return 32'h028B0D43;
      5:  return 32'h0145D7E1;
      6:  return 32'h00A2F61E;
      7:  return 32'h00517C55;
      8:  return 32'h0028BE53;
      9:  return 32'h00145F2F;
      10: return 32'h000A2F98;
      11: return 32'h000517CC;
      12: return 32'h00028BE6;
      13: return 32'h000145F3;
      14: return 32'h0000A2FA;
      15: return 32'h0000517D;
      16: return 32'h000028BE;
      17: return 32'h0000145F;
      18: return 32'h00000A30;
      19: return 32'h00000518;
      20: return 32'h0000028C;
      21: return 32'h00000146;
      22: return 32'h000000A3;
      23: return 32'h00000051;
      24: return 32'h00000029;
      25: return 32'h00000014;
      26: return 32'h0000000A;
      27: return 32'h00000005;
      28: return 32'h00000003;
      29: return 32'h00000001;
      30: return 32'h00000001;
      default: return 32'h00000000;
    endcase
  endfunction

  // Same constant rounded to an aw-bit angle format (aw <= 32).
  function automatic logic [31:0] atan_units(input int i, input int aw);
    logic [32:0] t;
    t = {1'b0, atan_q31(i)};
    if (aw >= 32) return t[31:0];
    t = (t + (33'd1 << (31 - aw))) >> (32 - aw);
    return t[31:0];
  endfunction

endpackage

// File: rtl/cordic_vec_prerot.sv
module cordic_vec_prerot #(
  parameter int W  = 16,
  parameter int AW = 16,
  parameter int IW = W + cordic_vec_pkg::GUARD
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vi,
  input  logic signed [W-1:0]  xi,
  input  logic signed [W-1:0]  yi,
  input  logic        [AW-1:0] zi,
  output logic                 vo,
  output logic signed [IW-1:0] xo,
  output logic signed [IW-1:0] yo,
  output logic        [AW-1:0] zo
);
  localparam int EXT = IW - W;
  localparam logic [AW-1:0] QTR = {2'b01, {(AW-2){1'b0}}};

  logic signed [IW-1:0] xe, ye;
  assign xe = {{EXT{xi[W-1]}}, xi};
  assign ye = {{EXT{yi[W-1]}}, yi};

  always_ff @(posedge clk) begin
    if (rst) begin
      vo <= 1'b0;
      xo <= '0;
      yo <= '0;
      zo <= '0;
    end else begin
      vo <= vi;
      if (vi) begin
        if (!xi[W-1]) begin
          xo <= xe;
          yo <= ye;
          zo <= zi;
        end else if (!yi[W-1]) begin
          // upper-left: turn clockwise by a quarter
          xo <= ye;
          yo <= -xe;
          zo <= zi + QTR;
        end else begin
          // lower-left: turn counter-clockwise by a quarter
          xo <= -ye;
          yo <= xe;
          zo <= zi - QTR;
        end
      end
    end
  end
endmodule

// File: rtl/cordic_vec_stage.sv
module cordic_vec_stage #(
  parameter int            IW    = 18,
  parameter int            AW    = 16,
  parameter int            SHIFT = 0,
  parameter logic [AW-1:0] ATAN  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vi,
  input  logic signed [IW-1:0] xi,
  input  logic signed [IW-1:0] yi,
  input  logic        [AW-1:0] zi,
  output logic                 vo,
  output logic signed [IW-1:0] xo,
  output logic signed [IW-1:0] yo,
  output logic        [AW-1:0] zo
);
  // Constant arithmetic shifts: wiring only.
  logic signed [IW-1:0] xsh, ysh;
  assign xsh = xi >>> SHIFT;
  assign ysh = yi >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      vo <= 1'b0;
      xo <= '0;
      yo <= '0;
      zo <= '0;
    end else begin
      vo <= vi;
      if (vi) begin
        if (yi[IW-1]) begin
          xo <= xi - ysh;
          yo <= yi + xsh;
          zo <= zi - ATAN;
        end else begin
          xo <= xi + ysh;
          yo <= yi - xsh;
          zo <= zi + ATAN;
        end
      end
    end
  end
endmodule

// File: rtl/cordic_vec_top.sv
module cordic_vec_top #(
  parameter int W      = 16,
  parameter int AW     = 16,
  parameter int STAGES = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  input  logic [AW-1:0]       in_phase,
  output logic                out_valid,
  output logic [W+1:0]        out_mag,
  output logic [AW-1:0]       out_phase
);
  localparam int IW = W + cordic_vec_pkg::GUARD;

  logic                 v_s [0:STAGES];
  logic signed [IW-1:0] x_s [0:STAGES];
  logic signed [IW-1:0] y_s [0:STAGES];
  logic        [AW-1:0] z_s [0:STAGES];

  cordic_vec_prerot #(.W(W), .AW(AW), .IW(IW)) u_pre (
    .clk(clk), .rst(rst),
    .vi(in_valid), .xi(in_x), .yi(in_y), .zi(in_phase),
    .vo(v_s[0]), .xo(x_s[0]), .yo(y_s[0]), .zo(z_s[0])
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam logic [AW-1:0] ANG = AW'(cordic_vec_pkg::atan_units(k, AW));
    cordic_vec_stage #(.IW(IW), .AW(AW), .SHIFT(k), .ATAN(ANG)) u_st (
      .clk(clk), .rst(rst),
      .vi(v_s[k]), .xi(x_s[k]), .yi(y_s[k]), .zi(z_s[k]),
      .vo(v_s[k+1]), .xo(x_s[k+1]), .yo(y_s[k+1]), .zo(z_s[k+1])
    );
  end

  assign out_valid = v_s[STAGES];
  assign out_mag   = x_s[STAGES];
  assign out_phase = z_s[STAGES];
endmodule

// File: rtl/cordic_vec_checker.sv
module cordic_vec_checker #(
  parameter int W      = 16,
  parameter int AW     = 16,
  parameter int STAGES = 14
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic signed [W-1:0] in_x,
  input logic signed [W-1:0] in_y,
  input logic                out_valid,
  input logic [W+1:0]        out_mag,
  input logic [AW-1:0]       out_phase
);
  localparam int LAT = STAGES + 1;

  // Independent tracking of accepted samples and of zero-vector samples.
  logic [LAT-1:0] vtrk, ztrk;
  always_ff @(posedge clk) begin
    if (rst) begin
      vtrk <= '0;
      ztrk <= '0;
    end else begin
      vtrk <= {vtrk[LAT-2:0], in_valid};
      ztrk <= {ztrk[LAT-2:0], in_valid && (in_x == '0) && (in_y == '0)};
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid == vtrk[LAT-1]);

  p_reset_r2: assert property (@(posedge clk)
    rst |=> !out_valid);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_mag[W+1]);

  p_zero_mag_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ztrk[LAT-1]) |-> (out_mag == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_mag) && $stable(out_phase)));
endmodule

bind cordic_vec_top cordic_vec_checker #(.W(W), .AW(AW), .STAGES(STAGES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
  .out_valid(out_valid), .out_mag(out_mag), .out_phase(out_phase)
);

// File: tb/cordic_vec_top_bench.sv
module cordic_vec_top_bench;
  localparam int W      = 16;
  localparam int AW     = 16;
  localparam int STAGES = 14;
  localparam int LAT    = STAGES + 1;
  localparam int QD     = 4096;
  localparam real PI    = 3.14159265358979323846;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] in_x = '0;
  logic signed [W-1:0] in_y = '0;
  logic [AW-1:0]       in_phase = '0;
  logic                out_valid;
  logic [W+1:0]        out_mag;
  logic [AW-1:0]       out_phase;

  always #2 clk = ~clk;

  cordic_vec_top #(.W(W), .AW(AW), .STAGES(STAGES)) u_cordic_vec_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_phase(in_phase), .out_valid(out_valid), .out_mag(out_mag),
    .out_phase(out_phase)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  longint cyc = 0;

  // expected-sample queue
  int            qx [QD];
  int            qy [QD];
  logic [AW-1:0] qz [QD];
  int            qk [QD];   // 0 random, 2 zero vector, 3 full-scale corner
  longint        qt [QD];
  int wr = 0;
  int rd = 0;

  logic [W+1:0]  last_mag;
  logic [AW-1:0] last_ph;
  bit            seen = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic real gain();
    real g = 1.0;
    for (int i = 0; i < STAGES; i++) g = g * $sqrt(1.0 + 2.0 ** (-2.0 * i));
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, exp);
    end
  endtask

  task automatic send(input int x, input int y, input int z, input int kind);
    @(negedge clk);
    in_valid = 1'b1;
    in_x     = W'(x);
    in_y     = W'(y);
    in_phase = AW'(z);
    qx[wr % QD] = x;
    qy[wr % QD] = y;
    qz[wr % QD] = AW'(z);
    qk[wr % QD] = kind;
    qt[wr % QD] = cyc;
    wr++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_x = W'($urandom);
      in_y = W'($urandom);
    end
  endtask

  // Output monitor: compares each result with a real-valued model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (rd >= wr) begin
          check(1'b0, "R8", "unexpected out_valid", 1.0, 0.0);
        end else begin
          int     x, y, k;
          real    r, em, ep_r, tol_p;
          longint ei;
          logic [AW-1:0]        ep;
          logic signed [AW-1:0] dph;
          string  rq;
          x = qx[rd % QD];
          y = qy[rd % QD];
          k = qk[rd % QD];
          r = $sqrt(real'(x) * x + real'(y) * y);
          check(cyc - qt[rd % QD] == LAT, "R1", "latency",
                real'(cyc - qt[rd % QD]), real'(LAT));
          if (k == 2) begin
            check(out_mag == '0, "R6", "zero-vector magnitude", real'(out_mag), 0.0);
          end else begin
            em = gain() * r;
            rq = (k == 3) ? "R7" : ((x < 0) ? "R4" : "R3");
            check(!out_mag[W+1] &&
                  ((real'(out_mag) - em) <= real'(STAGES + 4)) &&
                  ((em - real'(out_mag)) <= real'(STAGES + 4)),
                  rq, "magnitude", real'(out_mag), em);
            if (r >= 512.0) begin
              ep_r  = real'(qz[rd % QD]) + $atan2(real'(y), real'(x)) * (2.0 ** (AW - 1)) / PI;
              ei    = longint'(ep_r);
              ep    = AW'(ei);
              dph   = out_phase - ep;
              tol_p = 10.0 + 2.0 * STAGES * (2.0 ** (AW - 1)) / (PI * r);
              rq    = (x < 0) ? "R4" : "R5";
              check((dph < 0 ? -real'(dph) : real'(dph)) <= tol_p, rq, "phase",
                    real'(out_phase), real'(ep));
            end
          end
          rd++;
        end
        last_mag = out_mag;
        last_ph  = out_phase;
        seen     = 1'b1;
      end else if (seen) begin
        check(out_mag == last_mag && out_phase == last_ph, "R8", "hold in empty slot",
              real'(out_mag), real'(last_mag));
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", rd, wr);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R2: samples offered during reset must never emerge
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_x = W'(1000 + i);
      in_y = W'(i);
      check(out_valid == 1'b0, "R2", "out_valid in reset", real'(out_valid), 0.0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;
    for (int i = 0; i < LAT + 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R2", "out_valid after reset", real'(out_valid), 0.0);
    end

    // directed: axes, quarter-turn boundaries, origin, full-scale corners
    send(20000, 0, 0, 0);
    send(0, 20000, 0, 0);
    send(-20000, 0, 0, 0);
    send(0, -20000, 0, 0);
    send(-20000, 1, 100, 0);
    send(-20000, -1, -100, 0);
    send(-1, 20000, 0, 0);
    send(-1, -20000, 0, 0);
    send(0, 0, 0, 2);
    send(0, 0, 12345, 2);
    send(-32768, -32768, 0, 3);
    send(32767, 32767, 0, 3);
    send(-32768, 32767, 0, 3);
    send(32767, -32768, 16384, 3);
    send(-32768, 0, -32768, 3);
    idle(LAT + 2);

    // seeded random bursts with gaps
    for (int i = 0; i < 1500; i++) begin
      int x, y, z;
      x = int'($signed(W'($urandom)));
      y = int'($signed(W'($urandom)));
      z = int'($urandom % (1 << AW));
      send(x, y, z, 0);
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
    end
    idle(LAT + 4);

    check(rd == wr, "R1", "all samples returned", real'(rd), real'(wr));
    done = 1'b1;
    summary();
    $finish;
  end
endmodule